// File: doc/BRIEF.md
# Privileged Event-Selection Register Bank

This block holds the event-selection fields for up to sixteen auxiliary activity counters. It sits behind a system-register access port. Each request carries the instruction-style encoding fields, a read/write flag and 64-bit write data. With the request come the current privilege level (0 to 3) and a set of trap-control bits. The block decodes the encoding and picks one of the sixteen registers from it. It then decides, in a fixed priority order, whether to complete the access, to redirect it as a trap to a higher level, or to reject it as an undefined instruction.

Each register is 64 bits wide. Only the low 16 bits, the event number, are stored; the rest read as zero. Reads pass through a prioritised trap check. A write succeeds only at the highest implemented privilege level. Registers at or above the configured counter count are read-as-zero and write-ignored. Counters built with a fixed event are read-only. A write to a register whose counter is running is dropped and flagged. The response appears one clock after the request strobe.

Top module: `evtsel_bank`

## Requirements
- R1: An access is decoded only when op0=2'b11, op1=3'b011, crn=4'b1101 and crm[3:1]=3'b111. The register index is {crm[0], op2[2:0]}. Any other encoding raises `undef`.
- R2: A read returns the 16-bit event field in bits 15:0 and zero in bits 63:16. A write stores only wdata[15:0].
- R3: A read at level 0 is checked in this order:
  - when `user_en`=0, it traps to level 1, or to level 2 if `gen_redirect`=1 and `el2_en`=1;
  - otherwise, when `el2_mon_trap`=1 and `el2_en`=1, it traps to level 2;
  - otherwise, when `el3_mon_trap`=1 and `el3_present`=1, it traps to level 3;
  - otherwise the read completes.
- R4: A read at level 1 checks the level-2 condition and then the level-3 condition. A read at level 2 checks only the level-3 condition. A read at level 3 never traps.
- R5: Every trap reports `trap_ec`=6'h18, with `trap_el` set to the target level (1, 2 or 3).
- R6: The highest level is 3 when `el3_present`=1, otherwise 2 when `el2_en`=1, otherwise 1. A write at any other level raises `undef` and leaves the register unchanged. Writes are not subject to the trap checks.
- R7: When the index is at or above NUM_CNT (default 12), a read returns zero with `rd_valid`. A write from the highest level is acknowledged and has no effect.
- R8: A register whose bit is set in FIXED_MASK (default 16'h0003, registers 0 and 1) is read-only. A write to it from the highest level raises `undef`. This check takes priority over the R9 check.
- R9: A write to an in-range, non-fixed register whose `cnt_en` bit is 1 is acknowledged with `wr_err`=1 and leaves the register unchanged.
- R10: Each accepted request strobe produces, one cycle later, exactly one of `rd_valid`, `wr_ack`, `trap_valid` or `undef`. While reset is held or no request is present, all four are 0.
- R11: After reset, register i holds 16'h00A0+i with the default EVT_INIT. A fixed register always reads its EVT_INIT value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| op0 | input | 2 | Encoding field |
| op1 | input | 3 | Encoding field |
| crn | input | 4 | Encoding field |
| crm | input | 4 | Encoding field; bit 0 is index bit 3 |
| op2 | input | 3 | Encoding field; index bits 2:0 |
| wdata | input | 64 | Write data |
| cur_el | input | 2 | Current privilege level |
| user_en | input | 1 | Level-0 access enable |
| gen_redirect | input | 1 | Redirects level-0 traps to level 2 |
| el2_en | input | 1 | Level 2 is enabled |
| el2_mon_trap | input | 1 | Level-2 trap control |
| el3_present | input | 1 | Level 3 is implemented |
| el3_mon_trap | input | 1 | Level-3 trap control |
| cnt_en | input | 16 | Per-counter running flags |
| rd_valid | output | 1 | Read completed |
| rdata | output | 64 | Read data |
| wr_ack | output | 1 | Write completed or ignored |
| wr_err | output | 1 | Write dropped because the counter is running |
| trap_valid | output | 1 | Access trapped |
| trap_el | output | 2 | Trap target level |
| trap_ec | output | 6 | Trap class |
| undef | output | 1 | Undefined-instruction fault |

## Verification
Several rejection conditions can apply to the same request, and the response must show only the highest-priority one. For a level-0 read, the bench clears the user enable and also sets the level-2 trap control. It expects a level-1 trap, not a level-2 trap. For a write, it targets a fixed-event register whose counter is also running. It expects `undef` with no `wr_ack` and no `wr_err`. In both cases the bench checks that exactly one response line is high. It also reads the register back to confirm the stored field did not change.

// File: rtl/evtsel_pkg.sv
`timescale 1ns/1ps
package evtsel_pkg;
    localparam int MAXN = 16;
    localparam int EVW  = 16;
    localparam int DW   = 64;
    localparam int IDXW = 4;
    localparam logic [5:0] EC_MON = 6'h18;

    typedef enum logic [1:0] {LV0 = 2'd0, LV1 = 2'd1, LV2 = 2'd2, LV3 = 2'd3} lvl_e;

    typedef struct packed {
        logic            hit;
        logic [IDXW-1:0] idx;
    } dec_t;

    typedef struct packed {
        logic take;
        lvl_e tgt;
    } trap_t;

    typedef struct packed {
        logic          rd;
        logic          wack;
        logic          werr;
        logic          trap;
        logic          undef;
        lvl_e          tel;
        logic [DW-1:0] data;
    } rsp_t;

    function automatic logic [MAXN-1:0][EVW-1:0] default_init();
        logic [MAXN-1:0][EVW-1:0] r;
        for (int i = 0; i < MAXN; i++) r[i] = EVW'(16'h00A0 + i);
        return r;
    endfunction
endpackage

// File: rtl/evtsel_decode.sv
`timescale 1ns/1ps
module evtsel_decode
    import evtsel_pkg::*;
(
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output dec_t       dec
);
    always_comb begin
        dec.hit = (op0 == 2'b11) && (op1 == 3'b011) && (crn == 4'b1101) && (crm[3:1] == 3'b111);
        dec.idx = {crm[0], op2};
    end
endmodule

// File: rtl/evtsel_route.sv
`timescale 1ns/1ps
module evtsel_route
    import evtsel_pkg::*;
(
    input  lvl_e  cur,
    input  logic  user_en,
    input  logic  gen_redirect,
    input  logic  el2_en,
    input  logic  el2_mon_trap,
    input  logic  el3_present,
    input  logic  el3_mon_trap,
    output trap_t trap
);
    logic l2_hit, l3_hit;
    assign l2_hit = el2_en && el2_mon_trap;
    assign l3_hit = el3_present && el3_mon_trap;

    always_comb begin
        trap = '{take: 1'b0, tgt: LV1};
        unique case (cur)
            LV0: begin
                if (!user_en) begin
                    trap.take = 1'b1;
                    trap.tgt  = (el2_en && gen_redirect) ? LV2 : LV1;
                end else if (l2_hit) begin
                    trap.take = 1'b1;
                    trap.tgt  = LV2;
                end else if (l3_hit) begin
                    trap.take = 1'b1;
                    trap.tgt  = LV3;
                end
            end
            LV1: begin
                if (l2_hit) begin
                    trap.take = 1'b1;
                    trap.tgt  = LV2;
                end else if (l3_hit) begin
                    trap.take = 1'b1;
                    trap.tgt  = LV3;
                end
            end
            LV2: begin
                if (l3_hit) begin
                    trap.take = 1'b1;
                    trap.tgt  = LV3;
                end
            end
            default: trap.take = 1'b0;
        endcase
    end
endmodule

// File: rtl/evtsel_store.sv
`timescale 1ns/1ps
module evtsel_store
    import evtsel_pkg::*;
#(
    parameter int                         NUM_CNT    = 12,
    parameter logic [MAXN-1:0]            FIXED_MASK = 16'h0003,
    parameter logic [MAXN-1:0][EVW-1:0]   EVT_INIT   = default_init()
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [IDXW-1:0] widx,
    input  logic [EVW-1:0]  wval,
    input  logic [IDXW-1:0] ridx,
    output logic [EVW-1:0]  rval
);
    logic [EVW-1:0] fld [MAXN];

    for (genvar i = 0; i < MAXN; i++) begin : g_reg
        if (i >= NUM_CNT) begin : g_absent
            assign fld[i] = '0;
        end else if (FIXED_MASK[i]) begin : g_fixed
            assign fld[i] = EVT_INIT[i];
        end else begin : g_rw
            logic [EVW-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)                             q <= EVT_INIT[i];
                else if (we && widx == IDXW'(i))     q <= wval;
            end
            assign fld[i] = q;
        end
    end

    assign rval = fld[ridx];
endmodule

// File: rtl/evtsel_bank.sv
`timescale 1ns/1ps
module evtsel_bank
    import evtsel_pkg::*;
#(
    parameter int                         NUM_CNT    = 12,
    parameter logic [MAXN-1:0]            FIXED_MASK = 16'h0003,
    parameter logic [MAXN-1:0][EVW-1:0]   EVT_INIT   = default_init()
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [1:0]  op0,
    input  logic [2:0]  op1,
    input  logic [3:0]  crn,
    input  logic [3:0]  crm,
    input  logic [2:0]  op2,
    input  logic [63:0] wdata,
    input  logic [1:0]  cur_el,
    input  logic        user_en,
    input  logic        gen_redirect,
    input  logic        el2_en,
    input  logic        el2_mon_trap,
    input  logic        el3_present,
    input  logic        el3_mon_trap,
    input  logic [15:0] cnt_en,
    output logic        rd_valid,
    output logic [63:0] rdata,
    output logic        wr_ack,
    output logic        wr_err,
    output logic        trap_valid,
    output logic [1:0]  trap_el,
    output logic [5:0]  trap_ec,
    output logic        undef
);
    dec_t           dec;
    trap_t          trap;
    lvl_e           cur, highest;
    logic           in_range, fixed, we;
    logic [EVW-1:0] rval;
    rsp_t           rsp_d, rsp_q;

    assign cur     = lvl_e'(cur_el);
    assign highest = el3_present ? LV3 : (el2_en ? LV2 : LV1);

    evtsel_decode u_dec (
        .op0(op0), .op1(op1), .crn(crn), .crm(crm), .op2(op2), .dec(dec)
    );

    evtsel_route u_route (
        .cur(cur), .user_en(user_en), .gen_redirect(gen_redirect),
        .el2_en(el2_en), .el2_mon_trap(el2_mon_trap),
        .el3_present(el3_present), .el3_mon_trap(el3_mon_trap), .trap(trap)
    );

    assign in_range = {1'b0, dec.idx} < 5'(NUM_CNT);
    assign fixed    = FIXED_MASK[dec.idx];

    always_comb begin
        rsp_d = '0;
        we    = 1'b0;
        if (req_valid && !rst) begin
            if (!dec.hit) begin
                rsp_d.undef = 1'b1;
            end else if (!req_write) begin
                if (trap.take) begin
                    rsp_d.trap = 1'b1;
                    rsp_d.tel  = trap.tgt;
                end else begin
                    rsp_d.rd   = 1'b1;
                    rsp_d.data = {{(DW-EVW){1'b0}}, rval};
                end
            end else if (cur != highest) begin
                rsp_d.undef = 1'b1;
            end else if (!in_range) begin
                rsp_d.wack = 1'b1;
            end else if (fixed) begin
                rsp_d.undef = 1'b1;
            end else if (cnt_en[dec.idx]) begin
                rsp_d.wack = 1'b1;
                rsp_d.werr = 1'b1;
            end else begin
                rsp_d.wack = 1'b1;
                we         = 1'b1;
            end
        end
    end

    evtsel_store #(
        .NUM_CNT(NUM_CNT), .FIXED_MASK(FIXED_MASK), .EVT_INIT(EVT_INIT)
    ) u_store (
        .clk(clk), .rst(rst), .we(we), .widx(dec.idx), .wval(wdata[EVW-1:0]),
        .ridx(dec.idx), .rval(rval)
    );

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign rd_valid   = rsp_q.rd;
    assign rdata      = rsp_q.data;
    assign wr_ack     = rsp_q.wack;
    assign wr_err     = rsp_q.werr;
    assign trap_valid = rsp_q.trap;
    assign trap_el    = rsp_q.tel;
    assign trap_ec    = rsp_q.trap ? EC_MON : 6'h00;
    assign undef      = rsp_q.undef;

    assert_one_response_R10: assert property (@(posedge clk) disable iff (rst)
        $countones({rd_valid, wr_ack, trap_valid, undef}) == ($past(req_valid && !rst) ? 1 : 0));

    assert_trap_class_R5: assert property (@(posedge clk) disable iff (rst)
        trap_valid |-> (trap_ec == 6'h18 && trap_el != 2'd0));

    assert_write_level_R6: assert property (@(posedge clk) disable iff (rst)
        wr_ack |-> ($past(cur_el) == $past(highest)));

    assert_raz_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past({1'b0, dec.idx} >= 5'(NUM_CNT))) |-> rdata == '0);

    assert_top_level_no_trap_R4: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid && !rst && cur_el == 2'd3) |-> !trap_valid);

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> rdata[63:16] == '0);
endmodule

// File: tb/tb_evtsel_bank.sv
`timescale 1ns/1ps
module tb_evtsel_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  op0 = '0;
    logic [2:0]  op1 = '0;
    logic [3:0]  crn = '0, crm = '0;
    logic [2:0]  op2 = '0;
    logic [63:0] wdata = '0;
    logic [1:0]  cur_el = '0;
    logic        user_en = 1'b1, gen_redirect = 1'b0, el2_en = 1'b1, el2_mon_trap = 1'b0;
    logic        el3_present = 1'b1, el3_mon_trap = 1'b0;
    logic [15:0] cnt_en = '0;
    logic        rd_valid, wr_ack, wr_err, trap_valid, undef;
    logic [63:0] rdata;
    logic [1:0]  trap_el;
    logic [5:0]  trap_ec;

    int checks = 0;
    int errors = 0;

    logic        c_rd, c_wack, c_werr, c_trap, c_undef;
    logic [63:0] c_data;
    logic [1:0]  c_tel;
    logic [5:0]  c_ec;

    always #2.5 clk = ~clk;

    evtsel_bank dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .op0(op0), .op1(op1), .crn(crn), .crm(crm), .op2(op2), .wdata(wdata),
        .cur_el(cur_el), .user_en(user_en), .gen_redirect(gen_redirect),
        .el2_en(el2_en), .el2_mon_trap(el2_mon_trap), .el3_present(el3_present),
        .el3_mon_trap(el3_mon_trap), .cnt_en(cnt_en), .rd_valid(rd_valid),
        .rdata(rdata), .wr_ack(wr_ack), .wr_err(wr_err), .trap_valid(trap_valid),
        .trap_el(trap_el), .trap_ec(trap_ec), .undef(undef)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic raw(input logic wr, input logic [1:0] o0, input logic [2:0] o1,
                       input logic [3:0] cn, input logic [3:0] cm, input logic [2:0] o2,
                       input logic [63:0] wd, input logic [1:0] el);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; op0 = o0; op1 = o1; crn = cn; crm = cm;
        op2 = o2; wdata = wd; cur_el = el;
        @(negedge clk);
        req_valid = 1'b0;
        c_rd = rd_valid; c_wack = wr_ack; c_werr = wr_err; c_trap = trap_valid;
        c_undef = undef; c_data = rdata; c_tel = trap_el; c_ec = trap_ec;
        chk("R10", 64'({c_rd, c_wack, c_trap, c_undef} == 4'b1000 ||
                       {c_rd, c_wack, c_trap, c_undef} == 4'b0100 ||
                       {c_rd, c_wack, c_trap, c_undef} == 4'b0010 ||
                       {c_rd, c_wack, c_trap, c_undef} == 4'b0001), 64'd1);
    endtask

    task automatic acc(input logic wr, input logic [3:0] idx, input logic [63:0] wd, input logic [1:0] el);
        raw(wr, 2'b11, 3'b011, 4'b1101, {3'b111, idx[3]}, idx[2:0], wd, el);
    endtask

    task automatic exp_read(input string req, input logic [63:0] v);
        chk(req, 64'(c_rd), 64'd1);
        chk(req, c_data, v);
    endtask

    task automatic exp_trap(input string req, input logic [1:0] el);
        chk(req, 64'(c_trap), 64'd1);
        chk(req, 64'(c_tel), 64'(el));
        chk("R5", 64'(c_ec), 64'h18);
    endtask

    task automatic exp_undef(input string req);
        chk(req, 64'(c_undef), 64'd1);
        chk(req, 64'(c_werr), 64'd0);
    endtask

    task automatic exp_wack(input string req, input logic err);
        chk(req, 64'(c_wack), 64'd1);
        chk(req, 64'(c_werr), 64'(err));
    endtask

    task automatic set_ctl(input logic ue, input logic gr, input logic e2, input logic t2,
                           input logic e3, input logic t3);
        user_en = ue; gen_redirect = gr; el2_en = e2; el2_mon_trap = t2;
        el3_present = e3; el3_mon_trap = t3;
    endtask

    task automatic t_reset();
        chk("R10", 64'({rd_valid, wr_ack, trap_valid, undef, wr_err}), 64'd0);
        set_ctl(1, 0, 1, 0, 1, 0);
        acc(0, 4'd2, '0, 2'd3);  exp_read("R11", 64'h00A2);
        acc(0, 4'd11, '0, 2'd3); exp_read("R11", 64'h00AB);
    endtask

    task automatic t_decode();
        raw(0, 2'b11, 3'b010, 4'b1101, 4'b1110, 3'd0, '0, 2'd3); exp_undef("R1");
        raw(0, 2'b11, 3'b011, 4'b1101, 4'b1100, 3'd0, '0, 2'd3); exp_undef("R1");
        raw(0, 2'b11, 3'b011, 4'b1101, 4'b1111, 3'd1, '0, 2'd3); exp_read("R1", 64'h00A9);
    endtask

    task automatic t_write();
        acc(1, 4'd5, 64'hFFFF_0000_0000_1234, 2'd3); exp_wack("R2", 1'b0);
        acc(0, 4'd5, '0, 2'd3); exp_read("R2", 64'h1234);
    endtask

    task automatic t_write_level();
        set_ctl(1, 0, 1, 0, 1, 0);
        acc(1, 4'd6, 64'h5555, 2'd2); exp_undef("R6");
        acc(0, 4'd6, '0, 2'd3);       exp_read("R6", 64'h00A6);
        set_ctl(1, 0, 1, 0, 0, 0);
        acc(1, 4'd6, 64'h6666, 2'd2); exp_wack("R6", 1'b0);
        acc(1, 4'd7, 64'h7777, 2'd1); exp_undef("R6");
        set_ctl(1, 0, 0, 1, 0, 1);
        acc(1, 4'd7, 64'h7070, 2'd1); exp_wack("R6", 1'b0);
        set_ctl(1, 0, 1, 0, 1, 0);
        acc(0, 4'd6, '0, 2'd3); exp_read("R6", 64'h6666);
        acc(0, 4'd7, '0, 2'd3); exp_read("R6", 64'h7070);
    endtask

    task automatic t_el0();
        set_ctl(0, 0, 1, 1, 1, 1); acc(0, 4'd3, '0, 2'd0); exp_trap("R3", 2'd1);
        set_ctl(0, 1, 1, 0, 1, 0); acc(0, 4'd3, '0, 2'd0); exp_trap("R3", 2'd2);
        set_ctl(0, 1, 0, 0, 1, 0); acc(0, 4'd3, '0, 2'd0); exp_trap("R3", 2'd1);
        set_ctl(1, 0, 1, 1, 1, 1); acc(0, 4'd3, '0, 2'd0); exp_trap("R3", 2'd2);
        set_ctl(1, 0, 0, 1, 1, 1); acc(0, 4'd3, '0, 2'd0); exp_trap("R3", 2'd3);
        set_ctl(1, 0, 1, 0, 0, 1); acc(0, 4'd3, '0, 2'd0); exp_read("R3", 64'h00A3);
    endtask

    task automatic t_upper();
        set_ctl(0, 1, 1, 1, 1, 1); acc(0, 4'd4, '0, 2'd1); exp_trap("R4", 2'd2);
        set_ctl(0, 1, 1, 0, 1, 1); acc(0, 4'd4, '0, 2'd1); exp_trap("R4", 2'd3);
        set_ctl(0, 0, 1, 0, 0, 1); acc(0, 4'd4, '0, 2'd1); exp_read("R4", 64'h00A4);
        set_ctl(1, 0, 1, 1, 1, 0); acc(0, 4'd4, '0, 2'd2); exp_read("R4", 64'h00A4);
        set_ctl(1, 0, 1, 1, 1, 1); acc(0, 4'd4, '0, 2'd2); exp_trap("R4", 2'd3);
        set_ctl(0, 1, 1, 1, 1, 1); acc(0, 4'd4, '0, 2'd3); exp_read("R4", 64'h00A4);
        set_ctl(1, 0, 1, 0, 1, 0);
    endtask

    task automatic t_range();
        acc(0, 4'd12, '0, 2'd3); exp_read("R7", 64'h0);
        acc(1, 4'd13, 64'hBEEF, 2'd3); exp_wack("R7", 1'b0);
        acc(0, 4'd13, '0, 2'd3); exp_read("R7", 64'h0);
        acc(0, 4'd15, '0, 2'd3); exp_read("R7", 64'h0);
    endtask

    task automatic t_fixed();
        acc(1, 4'd0, 64'h1111, 2'd3); exp_undef("R8");
        acc(0, 4'd0, '0, 2'd3); exp_read("R8", 64'h00A0);
        cnt_en = 16'h0002;
        acc(1, 4'd1, 64'h2222, 2'd3); exp_undef("R8");
        chk("R8", 64'(c_wack), 64'd0);
        acc(0, 4'd1, '0, 2'd3); exp_read("R11", 64'h00A1);
        cnt_en = '0;
    endtask

    task automatic t_enabled();
        cnt_en = 16'h0100;
        acc(1, 4'd8, 64'h4321, 2'd3); exp_wack("R9", 1'b1);
        acc(0, 4'd8, '0, 2'd3); exp_read("R9", 64'h00A8);
        cnt_en = '0;
        acc(1, 4'd8, 64'h4321, 2'd3); exp_wack("R9", 1'b0);
        acc(0, 4'd8, '0, 2'd3); exp_read("R9", 64'h4321);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL R10 watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_decode();
        t_write();
        t_write_level();
        t_el0();
        t_upper();
        t_range();
        t_fixed();
        t_enabled();
        repeat (2) @(negedge clk);
        chk("R10", 64'({rd_valid, wr_ack, trap_valid, undef}), 64'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule